// File: doc/BRIEF.md
# Vector Gather/Scatter Sequencer

This block moves a sixteen-lane vector of 32-bit words between a register image and memory, with each lane's address chosen on its own. A command supplies a base byte address, one 16-bit index per lane and a lane mask. Each lane's address is the base plus four times its index, so the lanes may sit at any spacing, including repeated or out-of-order locations. In gather mode the block loads the enabled lanes. In scatter mode it stores them.

Once a command is accepted, the sequencer captures the lane addresses and the mask. It then loops: it checks for pending lanes, issues one line-sized memory transaction for the lowest pending lane, waits for its response and retires lanes. For a gather, one returned 64-byte line retires every pending lane that falls inside it. For a scatter, each transaction writes a single lane's four bytes. When no lane remains, the block pulses `done` together with the final vector and the (empty) mask.

All three streams use valid/ready handshakes:
- **Command:** taken on `cmd_valid && cmd_ready`. `cmd_ready` is high only while the block is idle.
- **Request:** once `req_valid` rises, it stays high with its address, write flag, data and byte enables unchanged until `req_ready` is seen.
- **Response:** `rsp_ready` is high only while one request is outstanding. The response may arrive any number of cycles later.

Top module: `vgs_seq`

## Requirements
- R1: `cmd_ready` is 1 exactly when no operation is in progress. A command is taken on a cycle with `cmd_valid && cmd_ready`. From then until the cycle after `done`, `cmd_ready` stays 0.
- R2: Lane i's byte address is `(cmd_base with bits [1:0] forced to 0) + 4*idx_i`, modulo 2^32. `idx_i` is `cmd_idx[16*i+15:16*i]`.
- R3: A gather request has `req_write=0`. Its `req_addr` is the 64-byte-aligned line address (bits [5:0] zero) of the lowest-numbered lane still pending.
- R4: When a gather response is consumed, every pending lane whose address bits [31:6] match the requested line is retired. Its mask bit clears, and its word is loaded from `rsp_data` bits `[32*k+31:32*k]`, where k is the lane address bits [5:2].
- R5: Lanes whose mask bit is 0 in the command are never requested or written. At completion they return their `cmd_vec` word (lane i at bits `[32*i+31:32*i]`) unchanged.
- R6: A command with an all-zero mask issues no request. Its `done` is high in the second cycle after the cycle in which the command was accepted.
- R7: At most one request is outstanding. `req_valid` is 0 from the request's handshake until its response has been consumed. While `req_valid` is high without `req_ready`, the request fields hold steady.
- R8: A scatter makes one write (`req_write=1`) per enabled lane, in ascending lane order, with these fields:
  - `req_addr`: the lane's line address.
  - `req_wdata`: the lane word placed at word slot k.
  - `req_be`: only bits `[4k+3:4k]` set, where k is the lane address bits [5:2].
  - Each write retires that lane when its response is consumed.
- R9: `done` is a one-cycle pulse. It is high in the second cycle after the last response was consumed, or after acceptance under R6. While `done` is high, `mask_out` is 0 and `vec_out` holds the final vector.
- R10: After reset, `cmd_ready=1`, `req_valid=0`, `rsp_ready=0` and `done=0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command may be taken |
| cmd_scatter | input | 1 | 1 = scatter (store), 0 = gather (load) |
| cmd_base | input | 32 | Base byte address |
| cmd_idx | input | 256 | Sixteen 16-bit lane indices, lane 0 lowest |
| cmd_mask | input | 16 | Lane enables, bit i = lane i |
| cmd_vec | input | 512 | Prior vector contents (gather) or store data (scatter) |
| req_valid | output | 1 | Memory request offered |
| req_ready | input | 1 | Memory accepts the request |
| req_write | output | 1 | 1 = write, 0 = line read |
| req_addr | output | 32 | Line-aligned byte address |
| req_wdata | output | 512 | Write line with the lane word in its slot |
| req_be | output | 64 | Byte enables for a write |
| rsp_valid | input | 1 | Response beat present |
| rsp_ready | output | 1 | Block is waiting for the response |
| rsp_data | input | 512 | Returned line (ignored for writes) |
| done | output | 1 | One-cycle completion pulse |
| vec_out | output | 512 | Assembled vector |
| mask_out | output | 16 | Remaining-lane mask |

## Verification
A corrupted pending mask shows at the ports at once, on the next request:
- a wrong request count or order;
- a wrong line address;
- or `done` arriving early or late, which is timed to the cycle against the last response.

A wrong captured lane address shows up in the next request's `req_addr`, or as a wrong word in `vec_out` at `done`. A wrong retirement rule shows as a surplus request, or as a lane filled from the wrong slot. Such a fault is caught one response later at the latest, because every handshake and the completion value are compared with an independently computed expectation.

// File: rtl/vgs_pkg.sv
package vgs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_REQ,
    ST_WAIT,
    ST_DONE
  } vgs_state_e;
endpackage

// File: rtl/vgs_lane_addr.sv
module vgs_lane_addr #(
  parameter int LANES    = 16,
  parameter int ADDR_W   = 32,
  parameter int IDX_W    = 16,
  parameter int WORD_LSB = 2,
  parameter int WADDR_W  = 30
) (
  input  logic [ADDR_W-1:0]        base,
  input  logic [LANES*IDX_W-1:0]   idx,
  output logic [LANES*WADDR_W-1:0] waddr
);
  // word-granular base: byte bits below the word size drop out (R2)
  logic [WADDR_W-1:0] base_w;
  assign base_w = WADDR_W'(base >> WORD_LSB);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign waddr[g*WADDR_W +: WADDR_W] = base_w + WADDR_W'(idx[g*IDX_W +: IDX_W]);
  end
endmodule

// File: rtl/vgs_lowest.sv
module vgs_lowest #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic [N-1:0]  vec,
  output logic [IW-1:0] pos,
  output logic          any
);
  always_comb begin
    pos = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) pos = IW'(i);
    end
  end
  assign any = |vec;
endmodule

// File: rtl/vgs_lane_slot.sv
module vgs_lane_slot #(
  parameter int WADDR_W = 30,
  parameter int OFF_W   = 4,
  parameter int WORD_W  = 32,
  parameter int LINE_W  = 512
) (
  input  logic [WADDR_W-1:0]       waddr,
  input  logic [WADDR_W-OFF_W-1:0] tag,
  input  logic                     pend,
  input  logic [LINE_W-1:0]        line,
  output logic                     hit,
  output logic [WORD_W-1:0]        word
);
  logic [OFF_W-1:0] off;
  assign off  = waddr[OFF_W-1:0];
  assign hit  = pend && (waddr[WADDR_W-1:OFF_W] == tag);
  assign word = line[off*WORD_W +: WORD_W];
endmodule

// File: rtl/vgs_seq.sv
module vgs_seq #(
  parameter int LANES      = 16,
  parameter int WORD_W     = 32,
  parameter int IDX_W      = 16,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  output logic                      cmd_ready,
  input  logic                      cmd_scatter,
  input  logic [ADDR_W-1:0]         cmd_base,
  input  logic [LANES*IDX_W-1:0]    cmd_idx,
  input  logic [LANES-1:0]          cmd_mask,
  input  logic [LANES*WORD_W-1:0]   cmd_vec,
  output logic                      req_valid,
  input  logic                      req_ready,
  output logic                      req_write,
  output logic [ADDR_W-1:0]         req_addr,
  output logic [LINE_BYTES*8-1:0]   req_wdata,
  output logic [LINE_BYTES-1:0]     req_be,
  input  logic                      rsp_valid,
  output logic                      rsp_ready,
  input  logic [LINE_BYTES*8-1:0]   rsp_data,
  output logic                      done,
  output logic [LANES*WORD_W-1:0]   vec_out,
  output logic [LANES-1:0]          mask_out
);
  localparam int LINE_W     = LINE_BYTES * 8;
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int WORD_LSB   = $clog2(WORD_BYTES);
  localparam int LINE_LSB   = $clog2(LINE_BYTES);
  localparam int WADDR_W    = ADDR_W - WORD_LSB;
  localparam int OFF_W      = LINE_LSB - WORD_LSB;
  localparam int TAG_W      = WADDR_W - OFF_W;
  localparam int LANE_W     = $clog2(LANES);
  localparam int WPL        = LINE_BYTES / WORD_BYTES;

  vgs_pkg::vgs_state_e state_q;
  logic                mode_q;
  logic [LANES-1:0]    mask_q;
  logic [LANE_W-1:0]   cur_q;
  logic [WADDR_W-1:0]  addr_q [LANES];
  logic [WORD_W-1:0]   vec_q  [LANES];

  // per-lane word addresses of the incoming command
  logic [LANES*WADDR_W-1:0] lane_waddr;
  vgs_lane_addr #(
    .LANES(LANES), .ADDR_W(ADDR_W), .IDX_W(IDX_W),
    .WORD_LSB(WORD_LSB), .WADDR_W(WADDR_W)
  ) u_addr (
    .base (cmd_base),
    .idx  (cmd_idx),
    .waddr(lane_waddr)
  );

  // lowest pending lane picks the next line (R3, R8 ordering)
  logic [LANE_W-1:0] low_pos;
  logic              low_any;
  vgs_lowest #(.N(LANES), .IW(LANE_W)) u_low (
    .vec(mask_q),
    .pos(low_pos),
    .any(low_any)
  );

  logic [WADDR_W-1:0] cur_waddr;
  logic [TAG_W-1:0]   cur_tag;
  logic [OFF_W-1:0]   cur_off;
  logic [WORD_W-1:0]  cur_word;
  assign cur_waddr = addr_q[cur_q];
  assign cur_tag   = cur_waddr[WADDR_W-1:OFF_W];
  assign cur_off   = cur_waddr[OFF_W-1:0];
  assign cur_word  = vec_q[cur_q];

  // line match and word extraction for every lane (R4)
  logic [LANES-1:0]  hit;
  logic [WORD_W-1:0] slot_word [LANES];
  for (genvar g = 0; g < LANES; g++) begin : g_slot
    vgs_lane_slot #(
      .WADDR_W(WADDR_W), .OFF_W(OFF_W), .WORD_W(WORD_W), .LINE_W(LINE_W)
    ) u_slot (
      .waddr(addr_q[g]),
      .tag  (cur_tag),
      .pend (mask_q[g]),
      .line (rsp_data),
      .hit  (hit[g]),
      .word (slot_word[g])
    );
    assign vec_out[g*WORD_W +: WORD_W] = vec_q[g];
  end

  logic take_cmd, take_rsp;
  assign take_cmd = (state_q == vgs_pkg::ST_IDLE) && cmd_valid;
  assign take_rsp = (state_q == vgs_pkg::ST_WAIT) && rsp_valid;

  // control: prime -> check -> request -> wait -> check ... -> done
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= vgs_pkg::ST_IDLE;
      mode_q  <= 1'b0;
      mask_q  <= '0;
      cur_q   <= '0;
    end else begin
      case (state_q)
        vgs_pkg::ST_IDLE: if (cmd_valid) begin
          mode_q  <= cmd_scatter;
          mask_q  <= cmd_mask;
          state_q <= vgs_pkg::ST_CHECK;
        end
        vgs_pkg::ST_CHECK: begin
          if (low_any) begin
            cur_q   <= low_pos;
            state_q <= vgs_pkg::ST_REQ;
          end else begin
            state_q <= vgs_pkg::ST_DONE;
          end
        end
        vgs_pkg::ST_REQ: if (req_ready) state_q <= vgs_pkg::ST_WAIT;
        vgs_pkg::ST_WAIT: if (rsp_valid) begin
          if (mode_q) mask_q <= mask_q & ~(LANES'(1) << cur_q);
          else        mask_q <= mask_q & ~hit;
          state_q <= vgs_pkg::ST_CHECK;
        end
        vgs_pkg::ST_DONE: state_q <= vgs_pkg::ST_IDLE;
        default: state_q <= vgs_pkg::ST_IDLE;
      endcase
    end
  end

  // datapath: lane addresses and vector words
  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (take_cmd) begin
        addr_q[i] <= lane_waddr[i*WADDR_W +: WADDR_W];
        vec_q[i]  <= cmd_vec[i*WORD_W +: WORD_W];
      end else if (take_rsp && !mode_q && hit[i]) begin
        vec_q[i]  <= slot_word[i];
      end
    end
  end

  assign cmd_ready = (state_q == vgs_pkg::ST_IDLE);
  assign req_valid = (state_q == vgs_pkg::ST_REQ);
  assign rsp_ready = (state_q == vgs_pkg::ST_WAIT);
  assign done      = (state_q == vgs_pkg::ST_DONE);
  assign req_write = mode_q;
  assign req_addr  = {cur_tag, {LINE_LSB{1'b0}}};
  assign mask_out  = mask_q;

  // scatter write line: one word slot and its byte enables (R8)
  always_comb begin
    for (int w = 0; w < WPL; w++) begin
      req_wdata[w*WORD_W +: WORD_W]     = (mode_q && cur_off == OFF_W'(w)) ? cur_word : '0;
      req_be[w*WORD_BYTES +: WORD_BYTES] = {WORD_BYTES{mode_q && cur_off == OFF_W'(w)}};
    end
  end

  // ---------------- assertions ----------------
  a_r1_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  a_r3_pick_pending: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> mask_q[cur_q]);

  a_r4_mask_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready) |=> ($countones(mask_out) < $countones($past(mask_out))));

  a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_write)
                                   && $stable(req_be)));

  a_r7_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_valid && rsp_ready));

  a_r8_be_width: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |-> ($countones(req_be) == WORD_BYTES));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_empty: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (mask_out == '0));
endmodule

// File: tb/vgs_seq_bench.sv
module vgs_seq_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic          cmd_valid, cmd_ready, cmd_scatter;
  logic [31:0]   cmd_base;
  logic [255:0]  cmd_idx;
  logic [15:0]   cmd_mask;
  logic [511:0]  cmd_vec;
  logic          req_valid, req_ready, req_write;
  logic [31:0]   req_addr;
  logic [511:0]  req_wdata;
  logic [63:0]   req_be;
  logic          rsp_valid, rsp_ready;
  logic [511:0]  rsp_data;
  logic          done;
  logic [511:0]  vec_out;
  logic [15:0]   mask_out;

  vgs_seq u_vgs_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_scatter(cmd_scatter),
    .cmd_base(cmd_base), .cmd_idx(cmd_idx), .cmd_mask(cmd_mask), .cmd_vec(cmd_vec),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .done(done), .vec_out(vec_out), .mask_out(mask_out)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  int lat_k = 0;

  typedef struct {
    logic [31:0]  addr;
    logic         wr;
    logic [511:0] wdata;
    logic [63:0]  be;
  } exp_req_t;
  exp_req_t exp_q[$];

  task automatic check(input bit ok, input string tag, input string msg);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  function automatic logic [31:0] mword(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'hC3A5_0F1E;
  endfunction

  function automatic logic [511:0] mline(input logic [31:0] line);
    logic [511:0] d;
    for (int w = 0; w < 16; w++) d[w*32 +: 32] = mword(line + 32'(w * 4));
    return d;
  endfunction

  task automatic run_op(input bit sc, input logic [31:0] base, input logic [15:0] idx [16],
                        input logic [15:0] mask, input logic [511:0] vin, input int lat_base,
                        input string name);
    logic [31:0]  a [16];
    logic [31:0]  ba;
    logic [511:0] exp_vec;
    logic [15:0]  pend;
    logic [31:0]  cur_line;
    int           since, cnt;
    bit           waiting, done_seen, hs_req, hs_rsp;
    exp_req_t     e;

    // expectation from the requirements (R2, R3, R4, R5, R8)
    ba = base & ~32'd3;
    for (int i = 0; i < 16; i++) a[i] = ba + {14'd0, idx[i], 2'b00};
    exp_vec = vin;
    exp_q.delete();
    if (!sc) begin
      pend = mask;
      while (pend != 0) begin
        int lo;
        lo = 0;
        for (int i = 15; i >= 0; i--) if (pend[i]) lo = i;
        e.addr = a[lo] & ~32'd63; e.wr = 1'b0; e.wdata = '0; e.be = '0;
        exp_q.push_back(e);
        for (int j = 0; j < 16; j++) begin
          if (pend[j] && ((a[j] & ~32'd63) == e.addr)) begin
            exp_vec[j*32 +: 32] = mword(a[j]);
            pend[j] = 1'b0;
          end
        end
      end
    end else begin
      for (int i = 0; i < 16; i++) begin
        if (mask[i]) begin
          int k;
          k = int'(a[i][5:2]);
          e.addr = a[i] & ~32'd63; e.wr = 1'b1;
          e.wdata = '0; e.wdata[k*32 +: 32] = vin[i*32 +: 32];
          e.be = 64'hF << (k * 4);
          exp_q.push_back(e);
        end
      end
    end

    // present the command
    @(posedge clk); #1;
    cmd_valid = 1'b1; cmd_scatter = sc; cmd_base = base; cmd_mask = mask; cmd_vec = vin;
    for (int i = 0; i < 16; i++) cmd_idx[i*16 +: 16] = idx[i];
    @(negedge clk);
    check(cmd_ready == 1'b1, "R1", $sformatf("%s idle ready act=%0b exp=1", name, cmd_ready));
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    since = 0; cnt = 0; waiting = 0; done_seen = 0; cur_line = '0;

    while (!done_seen) begin
      @(negedge clk);
      since++;
      cyc++;
      if (done) begin
        check(since == 2, "R9", $sformatf("%s done latency act=%0d exp=2", name, since));
        check(exp_q.size() == 0, "R3", $sformatf("%s missing requests act=%0d exp=0", name, exp_q.size()));
        check(mask_out == 16'h0, "R9", $sformatf("%s mask act=%h exp=0", name, mask_out));
        check(vec_out == exp_vec, sc ? "R5" : "R4",
              $sformatf("%s vec act=%h exp=%h", name, vec_out, exp_vec));
        done_seen = 1;
      end else begin
        check(cmd_ready == 1'b0, "R1", $sformatf("%s busy ready act=%0b exp=0", name, cmd_ready));
      end
      check(!(req_valid && waiting), "R7",
            $sformatf("%s second request while waiting act=1 exp=0", name));
      hs_req = req_valid && req_ready;
      hs_rsp = rsp_valid && rsp_ready;
      if (hs_req) begin
        if (exp_q.size() == 0) begin
          check(1'b0, sc ? "R8" : "R5", $sformatf("%s extra request addr=%h exp=none", name, req_addr));
        end else begin
          e = exp_q.pop_front();
          check(req_addr == e.addr && req_write == e.wr, sc ? "R8" : "R3",
                $sformatf("%s req addr/wr act=%h/%0b exp=%h/%0b", name, req_addr, req_write, e.addr, e.wr));
          if (e.wr)
            check(req_wdata == e.wdata && req_be == e.be, "R8",
                  $sformatf("%s be act=%h exp=%h wdata act=%h exp=%h", name, req_be, e.be, req_wdata, e.wdata));
        end
        cur_line = req_addr;
      end
      if (hs_rsp) since = 0;
      @(posedge clk); #1;
      if (hs_rsp) begin rsp_valid = 1'b0; waiting = 0; end
      if (hs_req) begin
        waiting = 1;
        cnt = lat_base + (lat_k * 5) % 7;
        lat_k++;
      end else if (waiting && !rsp_valid) begin
        if (cnt > 0) cnt--;
        if (cnt == 0) begin
          rsp_valid = 1'b1;
          rsp_data  = mline(cur_line);
        end
      end
      req_ready = ((cyc % 3) != 1);
    end
    @(negedge clk);
    check(done == 1'b0, "R9", $sformatf("%s done width act=%0b exp=0", name, done));
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0]  ix [16];
    logic [511:0] v;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_scatter = 1'b0; cmd_base = '0; cmd_idx = '0;
    cmd_mask = '0; cmd_vec = '0; req_ready = 1'b0; rsp_valid = 1'b0; rsp_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(cmd_ready == 1'b1 && req_valid == 1'b0 && rsp_ready == 1'b0 && done == 1'b0, "R10",
          $sformatf("reset act=%0b%0b%0b%0b exp=1000", cmd_ready, req_valid, rsp_ready, done));
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_ready == 1'b1 && req_valid == 1'b0 && done == 1'b0, "R10",
          $sformatf("post-reset act=%0b%0b%0b exp=100", cmd_ready, req_valid, done));

    for (int i = 0; i < 16; i++) v[i*32 +: 32] = 32'hDEAD_0000 + 32'(i);

    // R4: contiguous gather, one line serves all lanes
    for (int i = 0; i < 16; i++) ix[i] = 16'(i);
    run_op(1'b0, 32'h0000_1000, ix, 16'hFFFF, v, 3, "gather_contig");

    // R4 R5: non-linear indices, partial mask, lanes sharing lines
    for (int i = 0; i < 16; i++) ix[i] = 16'((i * i * 3) % 97);
    run_op(1'b0, 32'h0000_4000, ix, 16'hB5D7, v, 2, "gather_sparse");

    // R6: zero mask gather
    run_op(1'b0, 32'h0000_4000, ix, 16'h0000, v, 2, "gather_empty");

    // R3: every lane on its own line, long latency, descending addresses
    for (int i = 0; i < 16; i++) ix[i] = 16'((15 - i) * 16 + i);
    run_op(1'b0, 32'h0001_0000, ix, 16'hFFFF, v, 150, "gather_distinct");

    // R2: base low bits forced to zero, reversed indices
    for (int i = 0; i < 16; i++) ix[i] = 16'(15 - i);
    run_op(1'b0, 32'h0000_2003, ix, 16'h00FF, v, 1, "gather_unaligned_base");

    // R8: scatter, repeated lines still written lane by lane
    for (int i = 0; i < 16; i++) ix[i] = 16'((i * 37) % 50);
    run_op(1'b1, 32'h0000_8000, ix, 16'hF0F3, v, 4, "scatter_mix");

    // R8: scatter all lanes contiguous
    for (int i = 0; i < 16; i++) ix[i] = 16'(i);
    run_op(1'b1, 32'h0000_9040, ix, 16'hFFFF, v, 1, "scatter_full");

    // R6: zero mask scatter
    run_op(1'b1, 32'h0000_9040, ix, 16'h0000, v, 1, "scatter_empty");

    // R5: single lane gather far from the base
    for (int i = 0; i < 16; i++) ix[i] = 16'hFFF0 + 16'(i);
    run_op(1'b0, 32'h4000_0000, ix, 16'h0400, v, 5, "gather_single");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule